// File: doc/BRIEF.md
# ATA Task-File Register Decoder

This block is the host-facing register port of a storage card running in its disk-style mode. It decodes two active-low chip enables, three address bits and active-low read and write strobes. From these it selects a task-file register, the 16-bit data port, or the alternate pair of status and device-control registers, and it places each byte on the low or the high half of the 16-bit bus. Some addresses lead to one register on a read and to another on a write.

The data port drives a small internal sector buffer, a first-in first-out queue of 16-bit entries. Words go in and come out whole. Byte traffic is put together from an even byte and an odd byte, and the queue moves only when the odd byte is transferred. Toward the device core the block gives a one-cycle command pulse with the command byte, a one-cycle device-control pulse with a soft-reset level, the features byte, and an interrupt flag. The core raises this flag, and a read of the main status register clears it.

An access takes effect on the first clock edge at which its strobe is seen low. Read data is captured at that same edge and is driven from the next cycle until the strobe rises. Outside that window the bus reads zero.

Top module: `ata_taskfile_if`

## Requirements
- R1: After reset, sector count and sector number read 0x01, every other written register reads 0x00, the pending-interrupt flag is clear, and no strobe or bus enable is active.
- R2: In the primary bank (`ce2_n`=1, `ce1_n`=0), addresses 2 to 6 are sector count, sector number, cylinder low, cylinder high and card/head select. Each one stores a byte written on D7-D0 and returns it on D7-D0 with D15-D8 zero.
- R3: In the primary bank, address 1 reads the error input but a write there stores the features byte. Address 7 reads the status input but a write there issues a command.
- R4: A primary write to address 7 gives exactly one cycle of `cmd_stb`, with `cmd_byte` equal to the written byte. No other access raises `cmd_stb`.
- R5: In the alternate bank (`ce2_n`=0, `ce1_n`=1), a write to address 6 stores the device-control byte and gives exactly one cycle of `ctl_stb`. `soft_reset` follows bit 2 of that byte. A read there returns status on D7-D0 and the drive address on D15-D8.
- R6: An alternate-bank read of address 7 returns the drive address on D7-D0. A write there changes no register and raises no strobe.
- R7: A read of the primary status register gives a one-cycle `intack` and clears `irq_pending`. A read of alternate status leaves both untouched.
- R8: With both enables low, address 0 or 1 is the 16-bit data word. A write pushes `wdata` into the buffer and a read returns the oldest entry and pops it. The features byte is not changed.
- R9: A primary byte write at address 0 holds the even byte. An alternate-bank byte write at address 0 takes the odd byte from D15-D8 and pushes {odd, even}. Even-byte reads return the head's low byte without popping. Odd-byte reads return the head's high byte on D15-D8 and pop.
- R10: An alternate-bank access at address 1 reaches error (read) or features (write) on D15-D8.
- R11: `rdata_oe` is high only while `rd_n` is low after a valid select. Any other time `rdata` is zero. Invalid selects are both enables high, word access at addresses 2 to 7, and alternate addresses 2 to 5. These are not driven, and writes to them are ignored.
- R12: A data read of an empty buffer returns zero and pops nothing. A data push into a full buffer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Chip enable, low half / primary bank select |
| ce2_n | input | 1 | Chip enable, high half / alternate bank select |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, zero when not driven |
| rdata_oe | output | 1 | Read bus enable |
| status_in | input | 8 | Status byte from the device core |
| error_in | input | 8 | Error byte from the device core |
| drive_addr_in | input | 8 | Drive address byte from the device core |
| irq_set | input | 1 | Device core raises the pending interrupt |
| irq_pending | output | 1 | Interrupt pending flag |
| intack | output | 1 | One-cycle pulse on a status register read |
| cmd_stb | output | 1 | One-cycle command issue pulse |
| cmd_byte | output | 8 | Last command byte written |
| ctl_stb | output | 1 | One-cycle device-control write pulse |
| ctl_byte | output | 8 | Device-control register |
| soft_reset | output | 1 | Device-control bit 2 |
| features_o | output | 8 | Features register |

## Verification
The bench goes through every combination of enables and addresses, once for writes and once for reads, and compares each bus, strobe and register against a model that tracks the expected queue contents. This catches a swapped bank, a missing fall-through of word access at address 1 to the data port, or a byte placed on the wrong lane: any of these gives a wrong word in the sweep. Byte assembly is tested with an even read repeated twice before the odd read. A design that popped on the even byte would show the next entry on the second read. The status and alternate-status reads are compared directly, so a design that acknowledged on both would drop the interrupt early. Overfill and empty reads show whether a push was silently overwritten or whether stale data came out of an empty buffer.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [BYTE_W-1:0] SECCNT_RST = 8'h01;
    localparam logic [BYTE_W-1:0] SECNUM_RST = 8'h01;
    localparam int SRST_BIT = 2;

    // Register targets reached by one enable/address combination.
    typedef enum logic [3:0] {
        T_NONE,
        T_DWORD,
        T_DEVEN,
        T_DODD,
        T_ERRFEAT,
        T_SECCNT,
        T_SECNUM,
        T_CYLLO,
        T_CYLHI,
        T_HEAD,
        T_STATCMD,
        T_ALTCTL,
        T_DRVADR
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic hi;      // byte travels on D15-D8
    } sel_t;

    typedef struct packed {
        logic [BYTE_W-1:0] features;
        logic [BYTE_W-1:0] seccnt;
        logic [BYTE_W-1:0] secnum;
        logic [BYTE_W-1:0] cyllo;
        logic [BYTE_W-1:0] cylhi;
        logic [BYTE_W-1:0] head;
        logic [BYTE_W-1:0] devctl;
    } tf_regs_t;

    function automatic sel_t decode_sel(input logic c2n, input logic c1n,
                                        input logic [2:0] a);
        sel_t s;
        s.tgt = T_NONE;
        s.hi  = 1'b0;
        case ({c2n, c1n})
            2'b00: begin
                if (a[2:1] == 2'b00) s.tgt = T_DWORD;
            end
            2'b10: begin
                case (a)
                    3'd0:    s.tgt = T_DEVEN;
                    3'd1:    s.tgt = T_ERRFEAT;
                    3'd2:    s.tgt = T_SECCNT;
                    3'd3:    s.tgt = T_SECNUM;
                    3'd4:    s.tgt = T_CYLLO;
                    3'd5:    s.tgt = T_CYLHI;
                    3'd6:    s.tgt = T_HEAD;
                    default: s.tgt = T_STATCMD;
                endcase
            end
            2'b01: begin
                case (a)
                    3'd0: begin
                        s.tgt = T_DODD;
                        s.hi  = 1'b1;
                    end
                    3'd1: begin
                        s.tgt = T_ERRFEAT;
                        s.hi  = 1'b1;
                    end
                    3'd6:    s.tgt = T_ALTCTL;
                    3'd7:    s.tgt = T_DRVADR;
                    default: s.tgt = T_NONE;
                endcase
            end
            default: s.tgt = T_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                    input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] put_lane(input logic [BYTE_W-1:0] b,
                                                   input logic hi);
        return hi ? {b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, b};
    endfunction

    function automatic logic is_data(input tgt_e t);
        return (t == T_DWORD) || (t == T_DODD);
    endfunction

endpackage

// File: rtl/ata_tf_secbuf.sv
module ata_tf_secbuf #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              rd_go,
    input  sel_t              sel,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              irq_set,
    output tf_regs_t          regs,
    output logic              cmd_stb,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              ctl_stb,
    output logic              intack,
    output logic              irq_pending
);
    logic stat_rd;
    assign stat_rd = rd_go && (sel.tgt == T_STATCMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '{features: '0, seccnt: SECCNT_RST, secnum: SECNUM_RST,
                      cyllo: '0, cylhi: '0, head: '0, devctl: '0};
            cmd_stb     <= 1'b0;
            cmd_byte    <= '0;
            ctl_stb     <= 1'b0;
            intack      <= 1'b0;
            irq_pending <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            ctl_stb <= 1'b0;
            intack  <= stat_rd;
            if (wr_go) begin
                case (sel.tgt)
                    T_ERRFEAT: regs.features <= wbyte;
                    T_SECCNT:  regs.seccnt   <= wbyte;
                    T_SECNUM:  regs.secnum   <= wbyte;
                    T_CYLLO:   regs.cyllo    <= wbyte;
                    T_CYLHI:   regs.cylhi    <= wbyte;
                    T_HEAD:    regs.head     <= wbyte;
                    T_STATCMD: begin
                        cmd_stb  <= 1'b1;
                        cmd_byte <= wbyte;
                    end
                    T_ALTCTL: begin
                        regs.devctl <= wbyte;
                        ctl_stb     <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (irq_set)      irq_pending <= 1'b1;
            else if (stat_rd) irq_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
(
    input  sel_t              sel,
    input  logic [WORD_W-1:0] buf_head,
    input  logic [BYTE_W-1:0] seccnt,
    input  logic [BYTE_W-1:0] secnum,
    input  logic [BYTE_W-1:0] cyllo,
    input  logic [BYTE_W-1:0] cylhi,
    input  logic [BYTE_W-1:0] head,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] error_in,
    input  logic [BYTE_W-1:0] drive_addr_in,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        case (sel.tgt)
            T_DWORD:   word = buf_head;
            T_DEVEN:   word = put_lane(buf_head[BYTE_W-1:0], 1'b0);
            T_DODD:    word = put_lane(buf_head[WORD_W-1:BYTE_W], 1'b1);
            T_ERRFEAT: word = put_lane(error_in, sel.hi);
            T_SECCNT:  word = put_lane(seccnt, sel.hi);
            T_SECNUM:  word = put_lane(secnum, sel.hi);
            T_CYLLO:   word = put_lane(cyllo, sel.hi);
            T_CYLHI:   word = put_lane(cylhi, sel.hi);
            T_HEAD:    word = put_lane(head, sel.hi);
            T_STATCMD: word = put_lane(status_in, sel.hi);
            T_ALTCTL:  word = {drive_addr_in, status_in};
            T_DRVADR:  word = put_lane(drive_addr_in, 1'b0);
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
    import ata_tf_pkg::*;
#(
    parameter int BUF_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce1_n,
    input  logic        ce2_n,
    input  logic [2:0]  addr,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        rdata_oe,
    input  logic [7:0]  status_in,
    input  logic [7:0]  error_in,
    input  logic [7:0]  drive_addr_in,
    input  logic        irq_set,
    output logic        irq_pending,
    output logic        intack,
    output logic        cmd_stb,
    output logic [7:0]  cmd_byte,
    output logic        ctl_stb,
    output logic [7:0]  ctl_byte,
    output logic        soft_reset,
    output logic [7:0]  features_o
);
    sel_t              sel_now;
    logic              sel_ok;
    logic              rd_q, wr_q;
    logic              rd_fall, wr_fall, rd_go, wr_go;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] even_hold;
    logic              buf_push, buf_pop;
    logic [WORD_W-1:0] push_word, buf_head, rd_word, rd_hold;
    logic              buf_empty, buf_full;
    logic              rd_live;
    tf_regs_t          regs;

    assign sel_now = decode_sel(ce2_n, ce1_n, addr);
    assign sel_ok  = (sel_now.tgt != T_NONE);
    assign wbyte   = pick_lane(wdata, sel_now.hi);

    // Strobe edge detection: an access acts once, on its first low cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    assign rd_fall = !rd_n && rd_q;
    assign wr_fall = !wr_n && wr_q;
    assign rd_go   = rd_fall && sel_ok;
    assign wr_go   = wr_fall && sel_ok;

    // Data port: byte pairs commit on the odd byte.
    always_ff @(posedge clk) begin
        if (rst)                                   even_hold <= '0;
        else if (wr_go && sel_now.tgt == T_DEVEN)  even_hold <= wbyte;
    end

    assign buf_push  = wr_go && is_data(sel_now.tgt);
    assign buf_pop   = rd_go && is_data(sel_now.tgt);
    assign push_word = (sel_now.tgt == T_DWORD) ? wdata : {wbyte, even_hold};

    ata_tf_secbuf #(
        .DEPTH (BUF_DEPTH),
        .WIDTH (WORD_W)
    ) secbuf_i (
        .clk   (clk),
        .rst   (rst),
        .push  (buf_push),
        .pop   (buf_pop),
        .din   (push_word),
        .head  (buf_head),
        .empty (buf_empty),
        .full  (buf_full)
    );

    ata_tf_regs regs_i (
        .clk         (clk),
        .rst         (rst),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .sel         (sel_now),
        .wbyte       (wbyte),
        .irq_set     (irq_set),
        .regs        (regs),
        .cmd_stb     (cmd_stb),
        .cmd_byte    (cmd_byte),
        .ctl_stb     (ctl_stb),
        .intack      (intack),
        .irq_pending (irq_pending)
    );

    ata_tf_rdmux rdmux_i (
        .sel           (sel_now),
        .buf_head      (buf_head),
        .seccnt        (regs.seccnt),
        .secnum        (regs.secnum),
        .cyllo         (regs.cyllo),
        .cylhi         (regs.cylhi),
        .head          (regs.head),
        .status_in     (status_in),
        .error_in      (error_in),
        .drive_addr_in (drive_addr_in),
        .word          (rd_word)
    );

    // Read data is captured once per strobe so side effects cannot disturb it.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_live <= 1'b0;
            rd_hold <= '0;
        end else if (rd_fall) begin
            rd_live <= sel_ok;
            rd_hold <= sel_ok ? rd_word : '0;
        end else if (rd_n) begin
            rd_live <= 1'b0;
        end
    end

    assign rdata_oe   = rd_live && !rd_n;
    assign rdata      = rdata_oe ? rd_hold : '0;
    assign ctl_byte   = regs.devctl;
    assign soft_reset = regs.devctl[SRST_BIT];
    assign features_o = regs.features;

    logic unused_ok;
    assign unused_ok = buf_empty ^ buf_full;
endmodule

// File: rtl/ata_taskfile_if_chk.sv
module ata_taskfile_if_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_n,
    input logic        wr_n,
    input logic [15:0] rdata,
    input logic        rdata_oe,
    input logic        cmd_stb,
    input logic        ctl_stb,
    input logic        intack,
    input logic        irq_set,
    input logic        irq_pending
);
    assert_cmd_single_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);

    assert_cmd_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> $past(!wr_n));

    assert_ctl_single_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_stb |=> !ctl_stb);

    assert_intack_from_read_R7: assert property (@(posedge clk) disable iff (rst)
        intack |-> $past(!rd_n));

    assert_intack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (intack && !$past(irq_set)) |-> !irq_pending);

    assert_oe_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> !rd_n);

    assert_idle_bus_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == 16'h0000));
endmodule

bind ata_taskfile_if ata_taskfile_if_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .rdata       (rdata),
    .rdata_oe    (rdata_oe),
    .cmd_stb     (cmd_stb),
    .ctl_stb     (ctl_stb),
    .intack      (intack),
    .irq_set     (irq_set),
    .irq_pending (irq_pending)
);

// File: tb/ata_taskfile_if_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_if_tb_top;
    localparam int DEPTH = 4;
    localparam logic [7:0] STAT = 8'h50;
    localparam logic [7:0] ERRB = 8'h04;
    localparam logic [7:0] DRVA = 8'hC1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce1_n = 1'b1, ce2_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdata_oe;
    logic        irq_set = 1'b0;
    logic        irq_pending, intack, cmd_stb, ctl_stb, soft_reset;
    logic [7:0]  cmd_byte, ctl_byte, features_o;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [15:0] q[$];
    logic [7:0]  m_feat = 8'h00, m_cnt = 8'h01, m_num = 8'h01;
    logic [7:0]  m_clo = 8'h00, m_chi = 8'h00, m_head = 8'h00, m_ctl = 8'h00;
    logic [7:0]  m_even = 8'h00;

    always #2.5 clk = ~clk;

    ata_taskfile_if #(.BUF_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2_n(ce2_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .status_in(STAT), .error_in(ERRB), .drive_addr_in(DRVA),
        .irq_set(irq_set), .irq_pending(irq_pending), .intack(intack),
        .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .ctl_stb(ctl_stb),
        .ctl_byte(ctl_byte), .soft_reset(soft_reset), .features_o(features_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_rd(input logic c2, input logic c1,
                                          input logic [2:0] a);
        logic [15:0] h;
        h = (q.size() > 0) ? q[0] : 16'h0000;
        case ({c2, c1})
            2'b00: return (a < 3'd2) ? {1'b1, h} : 17'h0;
            2'b10: case (a)
                3'd0: return {1'b1, 8'h00, h[7:0]};
                3'd1: return {1'b1, 8'h00, ERRB};
                3'd2: return {1'b1, 8'h00, m_cnt};
                3'd3: return {1'b1, 8'h00, m_num};
                3'd4: return {1'b1, 8'h00, m_clo};
                3'd5: return {1'b1, 8'h00, m_chi};
                3'd6: return {1'b1, 8'h00, m_head};
                default: return {1'b1, 8'h00, STAT};
            endcase
            2'b01: case (a)
                3'd0: return {1'b1, h[15:8], 8'h00};
                3'd1: return {1'b1, ERRB, 8'h00};
                3'd6: return {1'b1, DRVA, STAT};
                3'd7: return {1'b1, 8'h00, DRVA};
                default: return 17'h0;
            endcase
            default: return 17'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic c2, input logic c1, input logic [2:0] a);
        case ({c2, c1})
            2'b00: return (a < 3'd2) ? "R8" : "R11";
            2'b10: return (a == 3'd0) ? "R9" : ((a == 3'd1 || a == 3'd7) ? "R3" : "R2");
            2'b01: return (a == 3'd0) ? "R9" : (a == 3'd1) ? "R10" :
                          (a == 3'd6) ? "R5" : (a == 3'd7) ? "R6" : "R11";
            default: return "R11";
        endcase
    endfunction

    task automatic bus_rd(input logic c2, input logic c1, input logic [2:0] a,
                          output logic [15:0] d, output logic oe, output logic ia);
        @(negedge clk);
        ce2_n = c2; ce1_n = c1; addr = a; rd_n = 1'b0;
        @(negedge clk);
        d = rdata; oe = rdata_oe; ia = intack;
        @(negedge clk);
        rd_n = 1'b1; ce2_n = 1'b1; ce1_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic c2, input logic c1, input logic [2:0] a,
                          input logic [15:0] w, output logic cs, output logic ks,
                          output logic late);
        @(negedge clk);
        ce2_n = c2; ce1_n = c1; addr = a; wdata = w; wr_n = 1'b0;
        @(negedge clk);
        cs = cmd_stb; ks = ctl_stb;
        @(negedge clk);
        late = cmd_stb | ctl_stb;
        wr_n = 1'b1; ce2_n = 1'b1; ce1_n = 1'b1;
        @(negedge clk);
    endtask

    // Read with model comparison and model side effects.
    task automatic rd_check(input logic c2, input logic c1, input logic [2:0] a);
        logic [16:0] e;
        logic [15:0] d;
        logic oe, ia;
        string t;
        e = exp_rd(c2, c1, a);
        t = rd_tag(c2, c1, a);
        bus_rd(c2, c1, a, d, oe, ia);
        chk(t, $sformatf("oe cs=%b%b a=%0d", c2, c1, a), {31'h0, oe}, {31'h0, e[16]});
        chk(t, $sformatf("data cs=%b%b a=%0d", c2, c1, a), {16'h0, d}, {16'h0, e[15:0]});
        if (q.size() > 0 && ((({c2, c1} == 2'b00) && a < 3'd2) ||
                             (({c2, c1} == 2'b01) && a == 3'd0)))
            void'(q.pop_front());
    endtask

    task automatic wr_check(input logic c2, input logic c1, input logic [2:0] a,
                            input logic [15:0] w);
        logic cs, ks, late;
        logic exp_cmd, exp_ctl;
        exp_cmd = ({c2, c1} == 2'b10) && (a == 3'd7);
        exp_ctl = ({c2, c1} == 2'b01) && (a == 3'd6);
        case ({c2, c1})
            2'b00: if (a < 3'd2 && q.size() < DEPTH) q.push_back(w);
            2'b10: case (a)
                3'd0: m_even = w[7:0];
                3'd1: m_feat = w[7:0];
                3'd2: m_cnt  = w[7:0];
                3'd3: m_num  = w[7:0];
                3'd4: m_clo  = w[7:0];
                3'd5: m_chi  = w[7:0];
                3'd6: m_head = w[7:0];
                default: ;
            endcase
            2'b01: case (a)
                3'd0: if (q.size() < DEPTH) q.push_back({w[15:8], m_even});
                3'd1: m_feat = w[15:8];
                3'd6: m_ctl  = w[7:0];
                default: ;
            endcase
            default: ;
        endcase
        bus_wr(c2, c1, a, w, cs, ks, late);
        chk("R4", $sformatf("cmd_stb cs=%b%b a=%0d", c2, c1, a), {31'h0, cs}, {31'h0, exp_cmd});
        chk("R5", $sformatf("ctl_stb cs=%b%b a=%0d", c2, c1, a), {31'h0, ks}, {31'h0, exp_ctl});
        chk("R4", "strobe one cycle", {31'h0, late}, 32'h0);
        if (exp_cmd) chk("R4", "cmd_byte", {24'h0, cmd_byte}, {24'h0, w[7:0]});
        chk("R3", "features_o", {24'h0, features_o}, {24'h0, m_feat});
        chk(({c2, c1} == 2'b01 && a == 3'd7) ? "R6" : "R5", "ctl_byte",
            {24'h0, ctl_byte}, {24'h0, m_ctl});
        chk("R5", "soft_reset", {31'h0, soft_reset}, {31'h0, m_ctl[2]});
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic oe, ia;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "rdata_oe", {31'h0, rdata_oe}, 32'h0);
        chk("R1", "cmd_stb", {31'h0, cmd_stb}, 32'h0);
        chk("R1", "ctl_stb", {31'h0, ctl_stb}, 32'h0);
        chk("R1", "irq_pending", {31'h0, irq_pending}, 32'h0);
        chk("R1", "features", {24'h0, features_o}, 32'h0);
        chk("R1", "ctl_byte", {24'h0, ctl_byte}, 32'h0);
        bus_rd(1'b1, 1'b0, 3'd2, d, oe, ia);
        chk("R1", "sector count", {16'h0, d}, 32'h0001);
        bus_rd(1'b1, 1'b0, 3'd3, d, oe, ia);
        chk("R1", "sector number", {16'h0, d}, 32'h0001);
        bus_rd(1'b1, 1'b0, 3'd4, d, oe, ia);
        chk("R1", "cylinder low", {16'h0, d}, 32'h0000);

        // Exhaustive read sweep on reset state (empty buffer, R12 reads)
        for (int i = 0; i < 32; i++) rd_check(1'(i >> 4), 1'(i >> 3), 3'(i));

        // Exhaustive write sweep, then read sweep
        for (int i = 0; i < 32; i++)
            wr_check(1'(i >> 4), 1'(i >> 3), 3'(i), 16'hA5C3 ^ 16'(i * 16'h1357));
        for (int i = 0; i < 32; i++) rd_check(1'(i >> 4), 1'(i >> 3), 3'(i));
        for (int i = 0; i < 32; i++)
            wr_check(1'(i >> 4), 1'(i >> 3), 3'(i), 16'h3C96 + 16'(i * 16'h0B21));
        for (int i = 0; i < 32; i++) rd_check(1'(i >> 4), 1'(i >> 3), 3'(i));
        while (q.size() > 0) rd_check(1'b0, 1'b0, 3'd0);

        // R5: soft reset bit set and cleared
        wr_check(1'b0, 1'b1, 3'd6, 16'h0004);
        chk("R5", "soft_reset high", {31'h0, soft_reset}, 32'h1);
        wr_check(1'b0, 1'b1, 3'd6, 16'h00FB);
        chk("R5", "soft_reset low", {31'h0, soft_reset}, 32'h0);

        // R9: byte assembly with literal values
        wr_check(1'b1, 1'b0, 3'd0, 16'hEE34);
        wr_check(1'b0, 1'b1, 3'd0, 16'h12EE);
        bus_rd(1'b1, 1'b0, 3'd0, d, oe, ia);
        chk("R9", "even byte", {16'h0, d}, 32'h0034);
        bus_rd(1'b1, 1'b0, 3'd0, d, oe, ia);
        chk("R9", "even byte no pop", {16'h0, d}, 32'h0034);
        bus_rd(1'b0, 1'b1, 3'd0, d, oe, ia);
        chk("R9", "odd byte high lane", {16'h0, d}, 32'h1200);
        void'(q.pop_front());
        bus_rd(1'b0, 1'b0, 3'd0, d, oe, ia);
        chk("R12", "empty after pop", {16'h0, d}, 32'h0000);

        // R8/R12: overfill then drain in order
        for (int i = 0; i < DEPTH + 2; i++)
            wr_check(1'b0, 1'b0, 3'(i & 1), 16'h1000 + 16'(i * 16'h0111));
        chk("R12", "model depth", q.size(), DEPTH);
        for (int i = 0; i < DEPTH + 1; i++) rd_check(1'b0, 1'b0, 3'(i & 1));

        // R7: interrupt acknowledge only on the primary status read
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        chk("R7", "pending raised", {31'h0, irq_pending}, 32'h1);
        bus_rd(1'b0, 1'b1, 3'd6, d, oe, ia);
        chk("R7", "alt status no intack", {31'h0, ia}, 32'h0);
        chk("R7", "alt status keeps pending", {31'h0, irq_pending}, 32'h1);
        bus_rd(1'b1, 1'b0, 3'd7, d, oe, ia);
        chk("R7", "status intack", {31'h0, ia}, 32'h1);
        chk("R7", "status clears pending", {31'h0, irq_pending}, 32'h0);
        chk("R7", "intack one cycle", {31'h0, intack}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule